// File: doc/BRIEF.md
# Interrupt Event Register with Bus Access Checker

This block collects single-cycle event pulses from a physical-layer controller and holds them in one sticky 16-bit event register. The sources are the error and idle counters, two timers, the elastic buffer, the line-state detector, the connection state machine and the transmit parity checker. The register is read over the processor register bus. A read returns the whole register and clears every bit it returned. An event that arrives in the same cycle as the read is kept for the next read.

The block also watches every access on the processor register bus and records an access-error event when an access is forbidden. The rules cover writes to read-only addresses, reads of write-only addresses, and writes to the pattern and timer registers while the controller is in a state that does not allow them. A 16-bit mask selects which event bits drive the interrupt output. That output is registered.

Top module: `evt_intr_reg`

## Requirements
- R1: After reset the event register is all zero, `irqOut` is 0, and `rdData` is 0 while no read is in progress.
- R2: A one-cycle pulse on an event input sets its own bit at the next clock edge, and the bit stays set until it is read. The bit positions are: 15 access error, 14 signal detect, 13 link-error threshold, 12 minimum-idle, 11 violation-symbol, 10 PHY invalid, 9 elastic buffer error, 8 noise timer expired, 7 connection timer expired, 6 join complete, 5 break entered, 4 self test, 3 trace propagation, 2 code done, 1 line-state match, 0 parity error.
- R3: A read of the event address (0x17) drives the current register contents onto `rdData` in the same cycle and clears exactly those bits at the clock edge. An event that arrives in the read cycle is set in the register and is returned by the next read. A read of any other address returns 0.
- R4: Bit 15 sets after any write to a read-only address and after any read of a write-only address. With the defaults, addresses 0x13 to 0x17 are read-only and 0x0E and 0x0F are write-only. Any other access leaves bit 15 clear.
- R5: A write to the pattern address (0x10) or the pattern-length address (0x11) sets bit 15 while `sigActive` is 1, and does not set it while `sigActive` is 0.
- R6: A write to the connection-timer address (0x12) sets bit 15 unless `inMaint` is 1.
- R7: A write to the noise-timer address (0x18) sets bit 15 unless `inMaint` is 1 and `noiseTmrOn` is 0.
- R8: While `parChkEn` is 0, a `parErr` pulse has no effect on bit 0. While `parChkEn` is 1, the pulse sets bit 0.
- R9: With `cntEvtSel` at 0, the increment pulses set bits 12 and 11 and the overflow pulses are ignored. With `cntEvtSel` at 1, the overflow pulses set those bits and the increment pulses are ignored. `minIdleLower` sets bit 12 in either setting.
- R10: Bit 1 sets in every cycle in which `lineState` equals `matchLs`.
- R11: Bit 14 sets in every cycle in which `sigDetect` is high.
- R12: `irqOut` is the OR of the event register ANDed with `irqMask`, delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busValid | input | 1 | Register access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 5 | Register address |
| rdData | output | 16 | Event register contents during a read of 0x17, otherwise 0 |
| sigActive | input | 1 | Pattern signalling in progress |
| inMaint | input | 1 | Connection state machine is in its maintenance state |
| noiseTmrOn | input | 1 | Noise timer is running |
| parChkEn | input | 1 | Transmit parity checking is enabled |
| cntEvtSel | input | 1 | Counter event select: 0 = increment, 1 = overflow |
| sigDetect | input | 1 | Signal detect level |
| linkErrThr | input | 1 | Link-error count reached its threshold |
| minIdleInc | input | 1 | Minimum-idle gap counter incremented |
| minIdleOvf | input | 1 | Minimum-idle gap counter overflowed |
| minIdleLower | input | 1 | Idle minimum detector moved to a lower value |
| vsymInc | input | 1 | Violation-symbol counter incremented |
| vsymOvf | input | 1 | Violation-symbol counter overflowed |
| phyInvalid | input | 1 | PHY invalid asserted |
| ebufErr | input | 1 | Elastic buffer overflow or underflow |
| noiseTmrExp | input | 1 | Noise timer reached zero |
| connTmrExp | input | 1 | Connection timer reached zero |
| joinDone | input | 1 | Connection joined and active |
| breakEnt | input | 1 | Connection state machine entered break |
| selfTest | input | 1 | Quiet or halt received during trace |
| traceProp | input | 1 | Master line state received during active or trace |
| codeDone | input | 1 | Signalling bit exchange or confidence test finished |
| lineState | input | 4 | Detected line-state code |
| matchLs | input | 4 | Programmed line-state code to match |
| parErr | input | 1 | Parity error on the transmit data pins |
| irqMask | input | 16 | Per-bit interrupt enable |
| irqOut | output | 1 | Registered interrupt request |

## Verification
The assertions assume that each event input is a pulse that is sampled on the clock. They also assume that `busValid` marks one access per cycle, with the address and direction stable in that cycle, and that the state inputs (`sigActive`, `inMaint`, `noiseTmrOn`, `parChkEn`, `cntEvtSel`) are stable around an access. The stimulus changes every input only at the falling edge. It holds an event for one cycle and presents each access for exactly one cycle. It sets the state inputs several cycles before the access they qualify. When no match is wanted, it keeps `lineState` different from `matchLs`, so that bit 1 does not set and mask the other checks.

// File: rtl/evt_intr_pkg.sv
package evt_intr_pkg;
  localparam int EVT_W = 16;

  localparam int B_PARITY  = 0;
  localparam int B_LSMATCH = 1;
  localparam int B_CODE    = 2;
  localparam int B_TRACE   = 3;
  localparam int B_SELFTST = 4;
  localparam int B_BREAK   = 5;
  localparam int B_JOIN    = 6;
  localparam int B_CONNTMR = 7;
  localparam int B_NOISTMR = 8;
  localparam int B_EBUF    = 9;
  localparam int B_PHYINV  = 10;
  localparam int B_VSYM    = 11;
  localparam int B_MINIDLE = 12;
  localparam int B_LINKERR = 13;
  localparam int B_SIGDET  = 14;
  localparam int B_ACCERR  = 15;

  typedef struct packed {
    logic accErr;  // forbidden access seen this cycle
    logic rdClr;   // event register is being read this cycle
  } ctrlStrobe_t;
endpackage

// File: rtl/evt_intr_ctrl.sv
module evt_intr_ctrl
  import evt_intr_pkg::*;
#(
  parameter int ADDR_W = 5,
  localparam int NREG = 1 << ADDR_W,
  parameter logic [ADDR_W-1:0] EVT_ADDR  = 5'h17,
  parameter logic [ADDR_W-1:0] PAT_ADDR  = 5'h10,
  parameter logic [ADDR_W-1:0] PLEN_ADDR = 5'h11,
  parameter logic [ADDR_W-1:0] CTMR_ADDR = 5'h12,
  parameter logic [ADDR_W-1:0] NTMR_ADDR = 5'h18,
  parameter logic [NREG-1:0]   RO_MAP    = 32'h00F8_0000,
  parameter logic [NREG-1:0]   WO_MAP    = 32'h0000_C000
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              sigActive,
  input  logic              inMaint,
  input  logic              noiseTmrOn,
  output ctrlStrobe_t       strobe
);
  logic isRd, isWr;
  logic roViol, woViol, patViol, ctmrViol, ntmrViol;

  assign isRd = busValid && !busWrite;
  assign isWr = busValid && busWrite;

  always_comb begin
    roViol   = isWr && RO_MAP[busAddr];
    woViol   = isRd && WO_MAP[busAddr];
    patViol  = isWr && sigActive && (busAddr == PAT_ADDR || busAddr == PLEN_ADDR);
    ctmrViol = isWr && (busAddr == CTMR_ADDR) && !inMaint;
    ntmrViol = isWr && (busAddr == NTMR_ADDR) && !(inMaint && !noiseTmrOn);
  end

  always_comb begin
    strobe.accErr = roViol || woViol || patViol || ctmrViol || ntmrViol;
    strobe.rdClr  = isRd && (busAddr == EVT_ADDR);
  end
endmodule

// File: rtl/evt_src_map.sv
module evt_src_map
  import evt_intr_pkg::*;
#(
  parameter int LS_W = 4
) (
  input  logic            parChkEn,
  input  logic            cntEvtSel,
  input  logic            sigDetect,
  input  logic            linkErrThr,
  input  logic            minIdleInc,
  input  logic            minIdleOvf,
  input  logic            minIdleLower,
  input  logic            vsymInc,
  input  logic            vsymOvf,
  input  logic            phyInvalid,
  input  logic            ebufErr,
  input  logic            noiseTmrExp,
  input  logic            connTmrExp,
  input  logic            joinDone,
  input  logic            breakEnt,
  input  logic            selfTest,
  input  logic            traceProp,
  input  logic            codeDone,
  input  logic [LS_W-1:0] lineState,
  input  logic [LS_W-1:0] matchLs,
  input  logic            parErr,
  output logic [EVT_W-1:0] setVec
);
  logic minIdleCnt, vsymCnt;

  // counter events: increment or overflow chosen by one select bit
  always_comb begin
    minIdleCnt = cntEvtSel ? minIdleOvf : minIdleInc;
    vsymCnt    = cntEvtSel ? vsymOvf    : vsymInc;
  end

  always_comb begin
    setVec            = '0;
    setVec[B_ACCERR]  = 1'b0;  // supplied by the access checker
    setVec[B_SIGDET]  = sigDetect;
    setVec[B_LINKERR] = linkErrThr;
    setVec[B_MINIDLE] = minIdleCnt || minIdleLower;
    setVec[B_VSYM]    = vsymCnt;
    setVec[B_PHYINV]  = phyInvalid;
    setVec[B_EBUF]    = ebufErr;
    setVec[B_NOISTMR] = noiseTmrExp;
    setVec[B_CONNTMR] = connTmrExp;
    setVec[B_JOIN]    = joinDone;
    setVec[B_BREAK]   = breakEnt;
    setVec[B_SELFTST] = selfTest;
    setVec[B_TRACE]   = traceProp;
    setVec[B_CODE]    = codeDone;
    setVec[B_LSMATCH] = (lineState == matchLs);
    setVec[B_PARITY]  = parErr && parChkEn;
  end
endmodule

// File: rtl/evt_intr_dp.sv
module evt_intr_dp
  import evt_intr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [EVT_W-1:0] setVec,
  input  logic [EVT_W-1:0] irqMask,
  output logic [EVT_W-1:0] evtQ,
  output logic [EVT_W-1:0] rdData,
  output logic             irqOut
);
  logic [EVT_W-1:0] setAll;

  always_comb begin
    setAll           = setVec;
    setAll[B_ACCERR] = setVec[B_ACCERR] || strobe.accErr;
  end

  // one sticky flop per event; a read clears the bits it returns
  for (genvar i = 0; i < EVT_W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) evtQ[i] <= 1'b0;
      else       evtQ[i] <= (evtQ[i] && !strobe.rdClr) || setAll[i];
    end
  end

  assign rdData = strobe.rdClr ? evtQ : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= |(evtQ & irqMask);
  end
endmodule

// File: rtl/evt_intr_reg.sv
module evt_intr_reg
  import evt_intr_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LS_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [15:0]       rdData,
  input  logic              sigActive,
  input  logic              inMaint,
  input  logic              noiseTmrOn,
  input  logic              parChkEn,
  input  logic              cntEvtSel,
  input  logic              sigDetect,
  input  logic              linkErrThr,
  input  logic              minIdleInc,
  input  logic              minIdleOvf,
  input  logic              minIdleLower,
  input  logic              vsymInc,
  input  logic              vsymOvf,
  input  logic              phyInvalid,
  input  logic              ebufErr,
  input  logic              noiseTmrExp,
  input  logic              connTmrExp,
  input  logic              joinDone,
  input  logic              breakEnt,
  input  logic              selfTest,
  input  logic              traceProp,
  input  logic              codeDone,
  input  logic [LS_W-1:0]   lineState,
  input  logic [LS_W-1:0]   matchLs,
  input  logic              parErr,
  input  logic [15:0]       irqMask,
  output logic              irqOut
);
  ctrlStrobe_t      strobe;
  logic [EVT_W-1:0] setVec;
  logic [EVT_W-1:0] evtQ;

  evt_intr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busValid  (busValid),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .sigActive (sigActive),
    .inMaint   (inMaint),
    .noiseTmrOn(noiseTmrOn),
    .strobe    (strobe)
  );

  evt_src_map #(.LS_W(LS_W)) u_map (
    .parChkEn    (parChkEn),
    .cntEvtSel   (cntEvtSel),
    .sigDetect   (sigDetect),
    .linkErrThr  (linkErrThr),
    .minIdleInc  (minIdleInc),
    .minIdleOvf  (minIdleOvf),
    .minIdleLower(minIdleLower),
    .vsymInc     (vsymInc),
    .vsymOvf     (vsymOvf),
    .phyInvalid  (phyInvalid),
    .ebufErr     (ebufErr),
    .noiseTmrExp (noiseTmrExp),
    .connTmrExp  (connTmrExp),
    .joinDone    (joinDone),
    .breakEnt    (breakEnt),
    .selfTest    (selfTest),
    .traceProp   (traceProp),
    .codeDone    (codeDone),
    .lineState   (lineState),
    .matchLs     (matchLs),
    .parErr      (parErr),
    .setVec      (setVec)
  );

  evt_intr_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .setVec (setVec),
    .irqMask(irqMask),
    .evtQ   (evtQ),
    .rdData (rdData),
    .irqOut (irqOut)
  );
endmodule

// File: rtl/evt_intr_chk.sv
module evt_intr_chk #(
  parameter int ADDR_W = 5,
  parameter int LS_W   = 4,
  localparam int NREG  = 1 << ADDR_W,
  parameter logic [NREG-1:0] RO_MAP = 32'h00F8_0000,
  parameter logic [ADDR_W-1:0] EVT_ADDR = 5'h17
) (
  input logic              clk,
  input logic              rstN,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic              sigDetect,
  input logic [LS_W-1:0]   lineState,
  input logic [LS_W-1:0]   matchLs,
  input logic              parChkEn,
  input logic [15:0]       irqMask,
  input logic              irqOut,
  input logic [15:0]       evtQ,
  input logic [15:0]       setVec,
  input logic [15:0]       rdData
);
  logic rdEvt;
  assign rdEvt = busValid && !busWrite && (busAddr == EVT_ADDR);

  // R3: without a read, no set bit is lost
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !rdEvt |=> ((evtQ & $past(evtQ)) == $past(evtQ)));

  // R3: after a read only freshly raised bits remain
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    rdEvt |=> ((evtQ & ~$past(setVec) & ~16'h8000) == 16'h0));

  // R3: read data mirrors the register during a read of it
  a_r3_rd_data: assert property (@(posedge clk) disable iff (!rstN)
    rdEvt |-> (rdData == evtQ));

  // R4: write to read-only address raises bit 15
  a_r4_ro_write: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWrite && RO_MAP[busAddr]) |=> evtQ[15]);

  // R8: parity bit stays clear while checking is off
  a_r8_no_parity: assert property (@(posedge clk) disable iff (!rstN)
    (!parChkEn && !evtQ[0]) |=> !evtQ[0]);

  // R10: line-state match sets bit 1
  a_r10_ls_match: assert property (@(posedge clk) disable iff (!rstN)
    (lineState == matchLs) |=> evtQ[1]);

  // R11: signal detect sets bit 14
  a_r11_sig_det: assert property (@(posedge clk) disable iff (!rstN)
    sigDetect |=> evtQ[14]);

  // R12: interrupt follows masked register one clock later
  a_r12_irq_follows: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqOut == |($past(evtQ) & $past(irqMask))));
endmodule

bind evt_intr_reg evt_intr_chk #(.ADDR_W(ADDR_W), .LS_W(LS_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busValid (busValid),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .sigDetect(sigDetect),
  .lineState(lineState),
  .matchLs  (matchLs),
  .parChkEn (parChkEn),
  .irqMask  (irqMask),
  .irqOut   (irqOut),
  .evtQ     (evtQ),
  .setVec   (setVec),
  .rdData   (rdData)
);

// File: tb/evt_intr_reg_tb.sv
module evt_intr_reg_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 0, busWrite = 0;
  logic [4:0] busAddr = '0;
  logic [15:0] rdData;
  logic sigActive = 0, inMaint = 1, noiseTmrOn = 0, parChkEn = 1, cntEvtSel = 0;
  logic sigDetect = 0, linkErrThr = 0, minIdleInc = 0, minIdleOvf = 0, minIdleLower = 0;
  logic vsymInc = 0, vsymOvf = 0, phyInvalid = 0, ebufErr = 0, noiseTmrExp = 0;
  logic connTmrExp = 0, joinDone = 0, breakEnt = 0, selfTest = 0, traceProp = 0;
  logic codeDone = 0, parErr = 0;
  logic [3:0] lineState = 4'h0, matchLs = 4'h5;
  logic [15:0] irqMask = '0;
  logic irqOut;

  int total = 0, bad = 0;
  bit done = 0;

  localparam logic [31:0] RO_MAP = 32'h00F8_0000;  // 0x13..0x17
  localparam logic [31:0] WO_MAP = 32'h0000_C000;  // 0x0E, 0x0F

  always #10 clk = ~clk;

  evt_intr_reg u_dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic readEvt(output logic [15:0] v);
    busValid = 1; busWrite = 0; busAddr = 5'h17;
    #1 v = rdData;
    tick();
    busValid = 0;
  endtask

  task automatic access(input logic [4:0] a, input logic w);
    busValid = 1; busWrite = w; busAddr = a;
    tick();
    busValid = 0;
  endtask

  task automatic setSrc(input int b, input logic val);
    case (b)
      13: linkErrThr = val;
      12: minIdleLower = val;
      11: vsymInc = val;
      10: phyInvalid = val;
      9:  ebufErr = val;
      8:  noiseTmrExp = val;
      7:  connTmrExp = val;
      6:  joinDone = val;
      5:  breakEnt = val;
      4:  selfTest = val;
      3:  traceProp = val;
      2:  codeDone = val;
      0:  parErr = val;
      default: ;
    endcase
  endtask

  task automatic pulse(input int b);
    setSrc(b, 1'b1);
    tick();
    setSrc(b, 1'b0);
  endtask

  function automatic logic expErr(input logic [4:0] a, input logic w, input logic sig,
                                  input logic mnt, input logic noi);
    if (!w) return WO_MAP[a];
    if (RO_MAP[a]) return 1'b1;
    if ((a == 5'h10 || a == 5'h11) && sig) return 1'b1;
    if (a == 5'h12 && !mnt) return 1'b1;
    if (a == 5'h18 && !(mnt && !noi)) return 1'b1;
    return 1'b0;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    @(negedge clk); @(negedge clk);
    // R1: reset state
    chk("R1 rdData", rdData, 16'h0);
    chk("R1 irqOut", {15'h0, irqOut}, 16'h0);
    rstN = 1;
    tick();
    readEvt(v);
    chk("R1 register", v, 16'h0);

    // R2: each pulsed source lands in its own bit
    for (int b = 0; b < 14; b++) begin
      if (b == 1) continue;
      pulse(b);
      tick();
      readEvt(v);
      chk($sformatf("R2 bit %0d", b), v, 16'(1) << b);
    end
    // R11: signal detect
    sigDetect = 1; tick(); sigDetect = 0;
    readEvt(v);
    chk("R11 sigDetect", v, 16'h4000);
    // R10: line-state match, and no set on mismatch
    lineState = 4'h5; tick(); lineState = 4'h0;
    readEvt(v);
    chk("R10 match", v, 16'h0002);
    lineState = 4'h3; tick(); lineState = 4'h0;
    readEvt(v);
    chk("R10 mismatch", v, 16'h0000);

    // R3: sticky over idle cycles, read clears, same-cycle event kept
    pulse(10);
    repeat (5) tick();
    setSrc(5, 1'b1);
    readEvt(v);
    setSrc(5, 1'b0);
    chk("R3 first read", v, 16'h0400);
    readEvt(v);
    chk("R3 kept event", v, 16'h0020);
    readEvt(v);
    chk("R3 cleared", v, 16'h0000);
    pulse(9);
    busValid = 1; busWrite = 0; busAddr = 5'h05;
    #1 chk("R3 other addr data", rdData, 16'h0);
    tick(); busValid = 0;
    readEvt(v);
    chk("R3 other addr no clear", v, 16'h0200);

    // R4: sweep all addresses both directions with legal state
    for (int a = 0; a < 32; a++) begin
      for (int w = 0; w < 2; w++) begin
        access(5'(a), w[0]);
        readEvt(v);
        chk($sformatf("R4 addr %0h w%0d", a, w), v,
            {expErr(5'(a), w[0], 1'b0, 1'b1, 1'b0), 15'h0});
      end
    end

    // R5 R6 R7: state-dependent write rules
    for (int s = 0; s < 8; s++) begin
      sigActive = s[0]; inMaint = s[1]; noiseTmrOn = s[2];
      tick();
      access(5'h10, 1'b1); readEvt(v);
      chk("R5 pattern", v, {expErr(5'h10, 1'b1, s[0], s[1], s[2]), 15'h0});
      access(5'h11, 1'b1); readEvt(v);
      chk("R5 length", v, {expErr(5'h11, 1'b1, s[0], s[1], s[2]), 15'h0});
      access(5'h12, 1'b1); readEvt(v);
      chk("R6 conn timer", v, {expErr(5'h12, 1'b1, s[0], s[1], s[2]), 15'h0});
      access(5'h18, 1'b1); readEvt(v);
      chk("R7 noise timer", v, {expErr(5'h18, 1'b1, s[0], s[1], s[2]), 15'h0});
    end
    sigActive = 0; inMaint = 1; noiseTmrOn = 0;

    // R8: parity gate
    parChkEn = 0; tick();
    pulse(0); readEvt(v);
    chk("R8 disabled", v, 16'h0);
    parChkEn = 1; tick();
    pulse(0); readEvt(v);
    chk("R8 enabled", v, 16'h0001);

    // R9: counter event select
    for (int sel = 0; sel < 2; sel++) begin
      cntEvtSel = sel[0]; tick();
      minIdleInc = 1; tick(); minIdleInc = 0; readEvt(v);
      chk("R9 minIdle inc", v, sel == 0 ? 16'h1000 : 16'h0);
      minIdleOvf = 1; tick(); minIdleOvf = 0; readEvt(v);
      chk("R9 minIdle ovf", v, sel == 1 ? 16'h1000 : 16'h0);
      vsymInc = 1; tick(); vsymInc = 0; readEvt(v);
      chk("R9 vsym inc", v, sel == 0 ? 16'h0800 : 16'h0);
      vsymOvf = 1; tick(); vsymOvf = 0; readEvt(v);
      chk("R9 vsym ovf", v, sel == 1 ? 16'h0800 : 16'h0);
      minIdleLower = 1; tick(); minIdleLower = 0; readEvt(v);
      chk("R9 lower", v, 16'h1000);
    end
    cntEvtSel = 0;

    // R12: interrupt with matching and non-matching masks
    for (int b = 2; b < 14; b += 3) begin
      for (int m = 0; m < 2; m++) begin
        irqMask = m ? (16'(1) << b) : ~(16'(1) << b);
        tick();
        pulse(b);
        chk($sformatf("R12 not yet b%0d", b), {15'h0, irqOut}, 16'h0);
        tick();
        chk($sformatf("R12 b%0d m%0d", b, m), {15'h0, irqOut}, {15'h0, m[0]});
        readEvt(v);
        tick();
        chk("R12 cleared", {15'h0, irqOut}, 16'h0);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule